// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits behind a dual-modulus prescaler in a synthesizer feedback path and turns the prescaler's output clock into one pulse for the phase comparator per programmed division period. It counts prescaler output cycles with a main counter loaded from B. A swallow counter loaded from A keeps the modulus-control line high for the first A of those B cycles. The prescaler therefore divides by P+1 for A cycles and by P for the remaining B-A cycles, which gives a total division of P*B+A from the oscillator to the comparator.

New A, B and prescaler-select values are sampled only when a period ends, so a period never mixes old and new settings. A synchronous hold input models counter reset and powerdown. While it is high, both counters sit in their load state and both outputs stay low. Counting resumes on the first prescaler cycle after release. The swallow field is always 7 bits wide at the port. A narrow build (parameter `A_W` = 4) uses only its low four bits.

Top module: `pswallow_div`

## Requirements
- R1: With B legal (3 to 2047), `div_o` is high for exactly one cycle in every B cycles of `clk_i`.
- R2: In each period `mod_o` is high on exactly the first A cycles and low on the remaining B-A cycles. It is never high when A=0 and is high throughout when A=B (A must not exceed B).
- R3: If each cycle with `mod_o` high counts as P+1 and each other cycle counts as P, a period sums to P*B+A. P is the low modulus when `psel_o`=0 and the high modulus when `psel_o`=1.
- R4: In a build with `A_W`=4, bits 6:4 of `a_i` have no effect, and the swallow count is `a_i[3:0]` (0 to 15).
- R5: A change of `a_i` or `b_i` in the middle of a period does not alter the current period. It takes effect from the period that begins after the next `div_o` pulse.
- R6: While `hold_i` is high, `div_o` and `mod_o` are low. After release, the cycle in which `hold_i` falls is cycle 0 of a new period: `mod_o` shows A>0 at once, and `div_o` comes B-1 clock edges later.
- R7: While `rst_ni` is low, `div_o`, `mod_o` and `psel_o` are low. After release, the first `div_o` is sampled B clock edges later.
- R8: `psel_o` takes the value of `psel_i` only at a period boundary (or while held). A mid-period change of `psel_i` leaves `psel_o` unchanged until the next `div_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Synchronous counter reset / powerdown load |
| psel_i | input | 1 | Prescaler modulus select (0 low pair, 1 high pair) |
| a_i | input | 7 | Swallow count A (upper bits unused when A_W=4) |
| b_i | input | B_W (11) | Main count B, 3 to 2047 |
| psel_o | output | 1 | Modulus select applied to the prescaler, updated at boundaries |
| mod_o | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| div_o | output | 1 | One-cycle divided pulse to the phase comparator |

## Verification
The bench instantiates two copies side by side. One uses `A_W`=7 with the 64/128 moduli. The other uses `A_W`=4 with the 8/16 moduli, which brings the ignored upper swallow bits and the 0 to 15 range within reach. The wide build is driven through A=0, A=B, A=127, B=3 and B=2047, and the oscillator-cycle total per period is recomputed from the observed modulus line. Mid-period updates, hold release and the first period after reset are checked by counting edges to the pulse.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int unsigned A_FIELD_W = 7;  // swallow field width at the port
  localparam int unsigned B_MIN     = 3;  // smallest legal main count
endpackage

// File: rtl/pswallow_main.sv
module pswallow_main #(
  parameter int unsigned B_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [B_W-1:0] b_i,
  output logic           tc_o
);
  import pswallow_pkg::*;

  logic [B_W-1:0] b_cnt;

  // counts B-1 down to 0; reaching 0 marks the last cycle of the period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     b_cnt <= '0;
    else if (load_i) b_cnt <= b_i - B_W'(1);
    else             b_cnt <= b_cnt - B_W'(1);
  end

  assign tc_o = (b_cnt == '0);

  // R1: only legal main counts are ever loaded
  p_b_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (b_i >= B_W'(B_MIN)));
endmodule

// File: rtl/pswallow_swallow.sv
module pswallow_swallow #(
  parameter int unsigned A_W  = 7,
  parameter int unsigned AF_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [AF_W-1:0] a_i,
  output logic            busy_o
);
  logic [A_W-1:0] a_eff;
  logic [A_W-1:0] a_cnt;

  generate
    if (A_W < AF_W) begin : g_narrow
      assign a_eff = a_i[A_W-1:0];  // upper field bits are don't-care
    end else begin : g_full
      assign a_eff = a_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              a_cnt <= '0;
    else if (load_i)          a_cnt <= a_eff;
    else if (a_cnt != '0)     a_cnt <= a_cnt - A_W'(1);
  end

  assign busy_o = (a_cnt != '0);

  // R2: once expired, the swallow count stays expired until a reload
  p_swallow_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load_i) |=> !busy_o);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int unsigned A_W = 7,
  parameter int unsigned B_W = 11
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              hold_i,
  input  logic                              psel_i,
  input  logic [pswallow_pkg::A_FIELD_W-1:0] a_i,
  input  logic [B_W-1:0]                    b_i,
  output logic                              psel_o,
  output logic                              mod_o,
  output logic                              div_o
);
  import pswallow_pkg::*;

  logic arm_q;
  logic psel_q;
  logic tc;
  logic busy;
  logic reload;
  logic run;

  // first edge after reset loads the counters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= 1'b1;
  end

  assign reload = !arm_q || hold_i || tc;
  assign run    = arm_q && !hold_i;

  pswallow_main #(.B_W(B_W)) i_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (reload),
    .b_i    (b_i),
    .tc_o   (tc)
  );

  pswallow_swallow #(.A_W(A_W), .AF_W(A_FIELD_W)) i_swallow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (reload),
    .a_i    (a_i),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psel_q <= 1'b0;
    else if (reload) psel_q <= psel_i;
  end

  assign psel_o = psel_q;
  assign div_o  = run && tc;
  assign mod_o  = run && busy;

  // R1: the divided pulse is one cycle wide
  p_div_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  // R2: modulus control only rises at the start of a period
  p_mod_rise_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_o) |-> $past(div_o || hold_i || !arm_q));

  // R8: prescaler select only moves at a boundary
  p_psel_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(psel_o) |-> $past(div_o || hold_i || !arm_q));

  // R6: a held cycle leaves the counters at period start, never at terminal
  p_no_tc_after_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> !div_o);
endmodule

// File: tb/test_pswallow_div.sv
module test_pswallow_div;
  localparam int P_LO_RF = 64;
  localparam int P_HI_RF = 128;
  localparam int P_LO_IF = 8;
  localparam int P_HI_IF = 16;

  typedef struct packed {
    logic        psel;
    logic [6:0]  a;
    logic [10:0] b;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 7'd0,   11'd3},
    '{1'b0, 7'd3,   11'd3},
    '{1'b1, 7'd5,   11'd10},
    '{1'b0, 7'd127, 11'd200},
    '{1'b1, 7'd0,   11'd2047},
    '{1'b1, 7'd64,  11'd130},
    '{1'b0, 7'd1,   11'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_hold = 1'b0, rf_psel = 1'b1;
  logic [6:0] rf_a = 7'd2;
  logic [10:0] rf_b = 11'd5;
  logic rf_psel_o, rf_mod, rf_div;
  logic if_hold = 1'b0, if_psel = 1'b1;
  logic [6:0] if_a = 7'b1110101;
  logic [10:0] if_b = 11'd20;
  logic if_psel_o, if_mod, if_div;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit use_if = 1'b0;

  always #10 clk = ~clk;

  pswallow_div #(.A_W(7), .B_W(11)) i_pswallow_div (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(rf_hold), .psel_i(rf_psel),
    .a_i(rf_a), .b_i(rf_b), .psel_o(rf_psel_o), .mod_o(rf_mod), .div_o(rf_div)
  );

  pswallow_div #(.A_W(4), .B_W(11)) i_pswallow_div_if (
    .clk_i(clk), .rst_ni(rst_n), .hold_i(if_hold), .psel_i(if_psel),
    .a_i(if_a), .b_i(if_b), .psel_o(if_psel_o), .mod_o(if_mod), .div_o(if_div)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  function automatic logic cur_mod();  return use_if ? if_mod : rf_mod; endfunction
  function automatic logic cur_div();  return use_if ? if_div : rf_div; endfunction
  function automatic logic cur_psel(); return use_if ? if_psel_o : rf_psel_o; endfunction

  task automatic wait_pulse();
    int n = 0;
    do begin step(); n++; end while (!cur_div() && n < 5000);
  endtask

  task automatic steps_to_pulse(output int len, output int mc);
    len = 0; mc = 0;
    do begin
      step(); len++;
      if (cur_mod()) mc++;
    end while (!cur_div() && len < 5000);
  endtask

  task automatic measure(output int len, output int mc, output int vco);
    int p;
    len = 0; mc = 0; vco = 0;
    do begin
      step(); len++;
      if (use_if) p = if_psel_o ? P_HI_IF : P_LO_IF;
      else        p = rf_psel_o ? P_HI_RF : P_LO_RF;
      if (cur_mod()) begin mc++; vco += p + 1; end
      else vco += p;
    end while (!cur_div() && len < 5000);
  endtask

  initial begin
    int len, mc, vco, p, n;
    // R7: reset state
    repeat (3) step();
    check(!rf_div && !rf_mod && !rf_psel_o, "R7 reset outputs", {rf_div, rf_mod, rf_psel_o}, 0);
    rf_psel = 1'b0;
    rst_n = 1'b1;
    steps_to_pulse(len, mc);
    check(len == 5, "R7 first pulse after reset", len, 5);

    // R1 R2 R3: vector table
    for (int i = 0; i < 7; i++) begin
      rf_psel = VECS[i].psel; rf_a = VECS[i].a; rf_b = VECS[i].b;
      wait_pulse();
      measure(len, mc, vco);
      p = VECS[i].psel ? P_HI_RF : P_LO_RF;
      check(len == int'(VECS[i].b), "R1 period", len, int'(VECS[i].b));
      check(mc == int'(VECS[i].a), "R2 mod cycles", mc, int'(VECS[i].a));
      check(vco == p * int'(VECS[i].b) + int'(VECS[i].a), "R3 total division",
            vco, p * int'(VECS[i].b) + int'(VECS[i].a));
    end

    // R5 R8: mid-period update
    rf_psel = 1'b0; rf_a = 7'd2; rf_b = 11'd10;
    wait_pulse();
    measure(len, mc, vco);
    repeat (3) step();
    rf_b = 11'd7; rf_a = 7'd4; rf_psel = 1'b1;
    n = 0;
    do begin
      step(); n++;
      check(rf_psel_o == 1'b0, "R8 select held mid-period", rf_psel_o, 0);
    end while (!rf_div && n < 5000);
    check(n == 7, "R5 current period unchanged", n, 7);
    measure(len, mc, vco);
    check(len == 7, "R5 new B applied", len, 7);
    check(mc == 4, "R5 new A applied", mc, 4);
    check(rf_psel_o == 1'b1, "R8 select applied at boundary", rf_psel_o, 1);
    check(vco == 128 * 7 + 4, "R3 total after update", vco, 128 * 7 + 4);

    // R6: hold and release
    rf_psel = 1'b0; rf_a = 7'd3; rf_b = 11'd8;
    wait_pulse();
    measure(len, mc, vco);
    repeat (2) step();
    rf_hold = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      check(!rf_div && !rf_mod, "R6 outputs low in hold", {rf_div, rf_mod}, 0);
    end
    rf_hold = 1'b0;
    #1;
    check(rf_mod == 1'b1, "R6 mod at restart cycle", rf_mod, 1);
    steps_to_pulse(len, mc);
    check(len == 7, "R6 pulse after release", len, 7);
    check(mc == 2, "R6 mod after release", mc, 2);

    // R4: narrow swallow build ignores upper field bits
    use_if = 1'b1;
    wait_pulse();
    measure(len, mc, vco);
    check(len == 20, "R4 narrow period", len, 20);
    check(mc == 5, "R4 upper bits ignored", mc, 5);
    check(vco == 16 * 20 + 5, "R3 narrow total", vco, 16 * 20 + 5);
    if_a = 7'b1111111; if_b = 11'd15; if_psel = 1'b0;
    wait_pulse();
    measure(len, mc, vco);
    check(mc == 15, "R4 narrow max swallow", mc, 15);
    check(vco == 8 * 15 + 15, "R3 narrow low modulus", vco, 8 * 15 + 15);

    finish_run();
  end
endmodule